// File: doc/BRIEF.md
# I2C Master Status and Interrupt Unit

This block holds the seven status flags of an I2C master controller and turns them into one interrupt line. The transfer sequencer reports events as one-cycle pulses: stop completed, target did not acknowledge, holding byte taken into the shifter, byte received, and transmit underrun. The host side reports its own one-cycle operations: a write of the transmit holding register, a read start, a read of the receive holding register, a read of the status word, and a transmit-unfreeze command. Interrupt sources are enabled and disabled through separate write strobes that carry a bit vector.

The transfer-done flag shows a live state rather than a latched event. A missing acknowledge raises the no-ack, done, transmit-room and frozen flags together. While the unit is frozen, the sequencer is told to hold off (`tx_hold`), so any byte queued in the holding register never reaches the bus. Only the explicit unfreeze command releases this state.

Top module: `i2c_sts_irq_unit`

## Requirements
- R1: After reset the status word is 7'h05 and the mask is 0, so `irq` and `tx_hold` are low. The status bit positions are: 0 done, 1 rx_avail, 2 tx_room, 3 no_ack, 4 rx_ovr, 5 tx_undr, 6 frozen.
- R2: done (bit 0) is cleared in the cycle after a holding-register write or a read start. It is set in the cycle after a stop-done event when the unit is not frozen. A status read leaves it unchanged.
- R3: In the cycle after a no-ack event, bits 0, 2, 3 and 6 are all set. This holds even when a clearing operation arrives in the same cycle.
- R4: While frozen (bit 6 = 1), the byte-taken and stop-done events have no effect on tx_room or done, and `tx_hold` is high.
- R5: frozen is cleared only by `host_lock_clr`. A status read leaves it set.
- R6: A status read clears no_ack, rx_ovr and tx_undr. An event that sets one of these flags in the same cycle as the read wins over the clear.
- R7: rx_avail (bit 1) is set by a byte-received event and cleared by a receive-register read. A byte-received event while rx_avail is set and no read is in the same cycle sets rx_ovr (bit 4).
- R8: tx_room (bit 2) is cleared by a holding-register write. It is set by a byte-taken event when the unit is not frozen.
- R9: An enable write sets the given mask bits. A disable write clears the given mask bits. When both name the same bit in the same cycle, the disable wins.
- R10: `irq` is high exactly when some status bit and its mask bit are both 1.
- R11: An underrun event sets tx_undr (bit 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_stop_done | input | 1 | Sequencer: holding register and shifter empty, stop sent |
| ev_nack | input | 1 | Sequencer: target did not acknowledge |
| ev_thr_taken | input | 1 | Sequencer: holding byte moved to shifter |
| ev_rx_byte | input | 1 | Sequencer: received byte placed in receive register |
| ev_underrun | input | 1 | Sequencer: transmit underrun |
| host_thr_wr | input | 1 | Host wrote the transmit holding register |
| host_start_rd | input | 1 | Host issued a read start |
| host_rhr_rd | input | 1 | Host read the receive register |
| host_status_rd | input | 1 | Host read the status word |
| host_lock_clr | input | 1 | Host unfreeze command |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_data | input | 7 | Bits to enable |
| idis_wr | input | 1 | Interrupt disable write strobe |
| idis_data | input | 7 | Bits to disable |
| status | output | 7 | Status word |
| irq_mask | output | 7 | Interrupt mask |
| irq | output | 1 | Interrupt request |
| tx_hold | output | 1 | Tells the sequencer not to take new holding data |

## Verification
The vector walk first drives a normal write and a normal read. These show that done follows the live transfer state and is not a read-to-clear flag. Back-to-back receive events without a read separate plain data arrival from overrun. A no-ack, followed by a queued write and by byte-taken and stop events while frozen, shows whether the freeze really blocks progress and survives a status read. Same-cycle collisions (status read with underrun, holding write with no-ack, enable with disable) show which side of each set/clear pair has priority.

// File: rtl/i2c_sts_pkg.sv
package i2c_sts_pkg;

    localparam int NFLAG = 7;

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef enum int {
        B_DONE = 0,
        B_RXA  = 1,
        B_TXR  = 2,
        B_NAK  = 3,
        B_OVR  = 4,
        B_UNR  = 5,
        B_FRZ  = 6
    } flag_bit_e;

    localparam flag_vec_t FLAG_RST = flag_vec_t'((1 << B_DONE) | (1 << B_TXR));

    typedef struct packed {
        logic stop_done;
        logic nack;
        logic thr_taken;
        logic rx_byte;
        logic underrun;
    } seq_ev_t;

    typedef struct packed {
        logic thr_wr;
        logic start_rd;
        logic rhr_rd;
        logic status_rd;
        logic lock_clr;
    } host_op_t;

    function automatic flag_vec_t mask_next(flag_vec_t cur, logic en_wr, flag_vec_t en,
                                            logic dis_wr, flag_vec_t dis);
        flag_vec_t en_v;
        flag_vec_t dis_v;
        en_v  = en_wr  ? en  : '0;
        dis_v = dis_wr ? dis : '0;
        return (cur | en_v) & ~dis_v;
    endfunction

endpackage

// File: rtl/i2c_sts_event_decode.sv
module i2c_sts_event_decode
    import i2c_sts_pkg::*;
(
    input  seq_ev_t   ev,
    input  host_op_t  op,
    input  flag_vec_t cur,
    output flag_vec_t set_v,
    output flag_vec_t clr_v
);
    logic frozen;
    assign frozen = cur[B_FRZ];

    always_comb begin
        set_v = '0;
        clr_v = '0;
        // done: live state of the transfer
        set_v[B_DONE] = (ev.stop_done & ~frozen) | ev.nack;
        clr_v[B_DONE] = op.thr_wr | op.start_rd;
        // receive data available
        set_v[B_RXA]  = ev.rx_byte;
        clr_v[B_RXA]  = op.rhr_rd;
        // room in the transmit holding register
        set_v[B_TXR]  = (ev.thr_taken & ~frozen) | ev.nack;
        clr_v[B_TXR]  = op.thr_wr;
        // pending events, cleared by a status read
        set_v[B_NAK]  = ev.nack;
        clr_v[B_NAK]  = op.status_rd;
        set_v[B_OVR]  = ev.rx_byte & cur[B_RXA] & ~op.rhr_rd;
        clr_v[B_OVR]  = op.status_rd;
        set_v[B_UNR]  = ev.underrun;
        clr_v[B_UNR]  = op.status_rd;
        // transmit freeze
        set_v[B_FRZ]  = ev.nack;
        clr_v[B_FRZ]  = op.lock_clr;
    end
endmodule

// File: rtl/i2c_sts_flag_bank.sv
module i2c_sts_flag_bank #(
    parameter int            W       = 7,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_cell
        logic r;
        always_ff @(posedge clk) begin
            if (rst)           r <= RST_VAL[g];
            else if (set_v[g]) r <= 1'b1;
            else if (clr_v[g]) r <= 1'b0;
        end
        assign q[g] = r;
    end
endmodule

// File: rtl/i2c_sts_mask.sv
module i2c_sts_mask
    import i2c_sts_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_wr,
    input  flag_vec_t en_bits,
    input  logic      dis_wr,
    input  flag_vec_t dis_bits,
    output flag_vec_t mask
);
    always_ff @(posedge clk) begin
        if (rst) mask <= '0;
        else     mask <= mask_next(mask, en_wr, en_bits, dis_wr, dis_bits);
    end
endmodule

// File: rtl/i2c_sts_irq_unit.sv
module i2c_sts_irq_unit
    import i2c_sts_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_stop_done,
    input  logic             ev_nack,
    input  logic             ev_thr_taken,
    input  logic             ev_rx_byte,
    input  logic             ev_underrun,
    input  logic             host_thr_wr,
    input  logic             host_start_rd,
    input  logic             host_rhr_rd,
    input  logic             host_status_rd,
    input  logic             host_lock_clr,
    input  logic             ien_wr,
    input  logic [NFLAG-1:0] ien_data,
    input  logic             idis_wr,
    input  logic [NFLAG-1:0] idis_data,
    output logic [NFLAG-1:0] status,
    output logic [NFLAG-1:0] irq_mask,
    output logic             irq,
    output logic             tx_hold
);
    seq_ev_t   ev;
    host_op_t  op;
    flag_vec_t set_v;
    flag_vec_t clr_v;

    assign ev = '{stop_done: ev_stop_done, nack: ev_nack, thr_taken: ev_thr_taken,
                  rx_byte: ev_rx_byte, underrun: ev_underrun};
    assign op = '{thr_wr: host_thr_wr, start_rd: host_start_rd, rhr_rd: host_rhr_rd,
                  status_rd: host_status_rd, lock_clr: host_lock_clr};

    i2c_sts_event_decode u_dec (
        .ev    (ev),
        .op    (op),
        .cur   (status),
        .set_v (set_v),
        .clr_v (clr_v)
    );

    i2c_sts_flag_bank #(.W(NFLAG), .RST_VAL(FLAG_RST)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_v),
        .clr_v (clr_v),
        .q     (status)
    );

    i2c_sts_mask u_mask (
        .clk      (clk),
        .rst      (rst),
        .en_wr    (ien_wr),
        .en_bits  (ien_data),
        .dis_wr   (idis_wr),
        .dis_bits (idis_data),
        .mask     (irq_mask)
    );

    assign irq     = |(status & irq_mask);
    assign tx_hold = status[B_FRZ];
endmodule

// File: rtl/i2c_sts_irq_chk.sv
module i2c_sts_irq_chk
    import i2c_sts_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ev_nack,
    input logic             ev_stop_done,
    input logic             host_thr_wr,
    input logic             host_start_rd,
    input logic             host_status_rd,
    input logic             host_lock_clr,
    input logic             idis_wr,
    input logic [NFLAG-1:0] idis_data,
    input logic [NFLAG-1:0] status,
    input logic [NFLAG-1:0] irq_mask
);
    assert_nack_sets_R3: assert property (@(posedge clk) disable iff (rst)
        ev_nack |=> (status[B_NAK] && status[B_DONE] && status[B_TXR] && status[B_FRZ]));

    assert_freeze_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (status[B_FRZ] && !host_lock_clr) |=> status[B_FRZ]);

    assert_done_rise_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(status[B_DONE]) |-> ($past(ev_nack) || ($past(ev_stop_done) && !$past(status[B_FRZ]))));

    assert_done_drop_R2: assert property (@(posedge clk) disable iff (rst)
        ((host_thr_wr || host_start_rd) && !ev_nack && !ev_stop_done) |=> !status[B_DONE]);

    assert_stsrd_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (host_status_rd && !ev_nack) |=> !status[B_NAK]);

    assert_disable_wins_R9: assert property (@(posedge clk) disable iff (rst)
        idis_wr |=> ((irq_mask & $past(idis_data)) == '0));
endmodule

bind i2c_sts_irq_unit i2c_sts_irq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .ev_nack        (ev_nack),
    .ev_stop_done   (ev_stop_done),
    .host_thr_wr    (host_thr_wr),
    .host_start_rd  (host_start_rd),
    .host_status_rd (host_status_rd),
    .host_lock_clr  (host_lock_clr),
    .idis_wr        (idis_wr),
    .idis_data      (idis_data),
    .status         (status),
    .irq_mask       (irq_mask)
);

// File: tb/i2c_sts_irq_unit_test.sv
module i2c_sts_irq_unit_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_stop_done = 0, ev_nack = 0, ev_thr_taken = 0, ev_rx_byte = 0, ev_underrun = 0;
    logic host_thr_wr = 0, host_start_rd = 0, host_rhr_rd = 0, host_status_rd = 0, host_lock_clr = 0;
    logic ien_wr = 0, idis_wr = 0;
    logic [6:0] ien_data = '0, idis_data = '0;
    logic [6:0] status, irq_mask;
    logic irq, tx_hold;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    i2c_sts_irq_unit uut (.*);

    // control bit masks
    localparam logic [11:0] C_STOP = 12'h001, C_NACK = 12'h002, C_TAKE = 12'h004,
                            C_RXB  = 12'h008, C_UNDR = 12'h010, C_THRW = 12'h020,
                            C_STRT = 12'h040, C_RHR  = 12'h080, C_SRD  = 12'h100,
                            C_LCLR = 12'h200, C_IEN  = 12'h400, C_IDIS = 12'h800;
    localparam int NV = 25;
    // {ctrl, ien_data, idis_data, exp status, exp mask, exp irq}
    localparam logic [40:0] VEC [NV] = '{
        {C_IEN,          7'h08, 7'h00, 7'h05, 7'h08, 1'b0},
        {C_THRW,         7'h00, 7'h00, 7'h00, 7'h08, 1'b0},
        {C_TAKE,         7'h00, 7'h00, 7'h04, 7'h08, 1'b0},
        {C_STOP,         7'h00, 7'h00, 7'h05, 7'h08, 1'b0},
        {C_SRD,          7'h00, 7'h00, 7'h05, 7'h08, 1'b0},
        {C_STRT,         7'h00, 7'h00, 7'h04, 7'h08, 1'b0},
        {C_RXB,          7'h00, 7'h00, 7'h06, 7'h08, 1'b0},
        {C_RXB,          7'h00, 7'h00, 7'h16, 7'h08, 1'b0},
        {C_RHR|C_SRD,    7'h00, 7'h00, 7'h04, 7'h08, 1'b0},
        {C_IEN|C_RXB,    7'h02, 7'h00, 7'h06, 7'h0A, 1'b1},
        {C_RHR,          7'h00, 7'h00, 7'h04, 7'h0A, 1'b0},
        {C_THRW,         7'h00, 7'h00, 7'h00, 7'h0A, 1'b0},
        {C_NACK,         7'h00, 7'h00, 7'h4D, 7'h0A, 1'b1},
        {C_THRW,         7'h00, 7'h00, 7'h48, 7'h0A, 1'b1},
        {C_TAKE|C_STOP,  7'h00, 7'h00, 7'h48, 7'h0A, 1'b1},
        {C_SRD,          7'h00, 7'h00, 7'h40, 7'h0A, 1'b0},
        {C_LCLR,         7'h00, 7'h00, 7'h00, 7'h0A, 1'b0},
        {C_TAKE,         7'h00, 7'h00, 7'h04, 7'h0A, 1'b0},
        {C_UNDR,         7'h00, 7'h00, 7'h24, 7'h0A, 1'b0},
        {C_SRD|C_UNDR,   7'h00, 7'h00, 7'h24, 7'h0A, 1'b0},
        {C_SRD,          7'h00, 7'h00, 7'h04, 7'h0A, 1'b0},
        {C_IEN|C_IDIS,   7'h7F, 7'h08, 7'h04, 7'h77, 1'b1},
        {C_IDIS,         7'h00, 7'h7F, 7'h04, 7'h00, 1'b0},
        {C_THRW|C_NACK,  7'h00, 7'h00, 7'h4D, 7'h00, 1'b0},
        {C_SRD|C_LCLR,   7'h00, 7'h00, 7'h05, 7'h00, 1'b0}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 21, 22:  return "R9";
            1, 2:       return "R2 R8";
            3, 4, 5:    return "R2";
            6, 7, 10:   return "R7";
            8:          return "R6 R7";
            9:          return "R10";
            11:         return "R8";
            12, 23:     return "R3";
            13, 14:     return "R4";
            15, 16:     return "R5 R6";
            17:         return "R8";
            18:         return "R11";
            19, 20:     return "R6";
            default:    return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [6:0] es, logic [6:0] em, logic ei);
        logic eh;
        eh = es[6];  // tx_hold follows the frozen bit
        checks++;
        if (status !== es || irq_mask !== em || irq !== ei || tx_hold !== eh) begin
            fails++;
            $display("FAIL %s: status=%h mask=%h irq=%b hold=%b expected status=%h mask=%h irq=%b hold=%b",
                     tag, status, irq_mask, irq, tx_hold, es, em, ei, eh);
        end
    endtask

    task automatic drive(logic [11:0] c, logic [6:0] ed, logic [6:0] dd);
        ev_stop_done   = c[0];  ev_nack       = c[1];  ev_thr_taken = c[2];
        ev_rx_byte     = c[3];  ev_underrun   = c[4];  host_thr_wr  = c[5];
        host_start_rd  = c[6];  host_rhr_rd   = c[7];  host_status_rd = c[8];
        host_lock_clr  = c[9];  ien_wr        = c[10]; idis_wr      = c[11];
        ien_data = ed; idis_data = dd;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", 7'h05, 7'h00, 1'b0);
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][40:29], VEC[i][28:22], VEC[i][21:15]);
            @(negedge clk);
            drive('0, '0, '0);
            check(tag_of(i), VEC[i][14:8], VEC[i][7:1], VEC[i][0]);
        end
        // freeze, enable everything, then reset mid-run
        drive(C_NACK | C_IEN, 7'h7F, 7'h00);
        @(negedge clk);
        drive('0, '0, '0);
        check("R3 R10", 7'h4D, 7'h7F, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset after run", 7'h05, 7'h00, 1'b0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule